// File: doc/BRIEF.md
# SECDED Lane Protector with Error Logging

This block sits between a host write/read data path and a memory controller. Host data arrives `LANES` × 64 bits wide. On the write side every 64-bit lane gets its own Hamming encoder, which turns it into a 72-bit single-error-correct, double-error-detect codeword. On the read side every returned 72-bit lane has its own decoder. The decoder repairs a single flipped bit and flags a double flip on a per-lane error output.

A 32-bit register port sets up the block and reports its state:
- saturating counters of corrected and uncorrectable lane errors, each with a programmable threshold and a sticky interrupt;
- a capture record of one error, holding its address, type, lane and syndrome, with a choice of keeping the first error or the latest one;
- a test mode that deliberately corrupts one or two check bits of every written lane.

When protection is switched off, lanes pass through unencoded and unchecked.

Top module: `ecc_guard`

## Requirements
- R1: With protection on, each 64-bit write lane becomes a 72-bit codeword. Bit 0 of the codeword is even parity over the whole word. Bits 1, 2, 4, 8, 16, 32 and 64 are check bits. The data bits fill the remaining positions in ascending order. A codeword returned unchanged reads back as the original data with its error bit low.
- R2: A lane whose returned codeword has exactly one flipped bit, at any position, reads back corrected, with its error bit low.
- R3: A lane with exactly two flipped bits raises its bit of `rd_err` (bit l for lane l). `rd_err` is only ever high together with `rd_valid`.
- R4: The single-error counter (register 2) grows by the number of lanes corrected in a read beat. The double-error counter (register 3) grows by the number of lanes flagged. Both counters stop at their all-ones value.
- R5: The status register (register 1) has bit 0 for single errors and bit 1 for double errors. A status bit sets in the cycle after its counter first exceeds its threshold (register 4 for single, register 5 for double), and it stays set. `irq_sbe` and `irq_dbe` mirror these bits.
- R6: Writing 1 to a status bit clears that bit and also clears its counter.
- R7: On a read beat with an error, the capture record is filled from the lowest-numbered erroneous lane. Register 6 holds the read address. Register 7 holds: bit 0 valid, bit 1 type (1 = double), bits 15:8 syndrome, bits 23:16 lane. The syndrome is {1, position} for a single flip, and {0, position_a XOR position_b} for a double flip.
- R8: Control bit 1 selects the capture mode. When it is 0, a valid record is kept. When it is 1, every error overwrites the record. Any write to register 7 clears the valid bit.
- R9: Control bits 3:2 select injection. 01 inverts codeword bit 1 of every written lane. 10 inverts bits 1 and 2. On readback the block reports a single error with syndrome 0x81 for 01, and a double error with syndrome 0x03 for 10.
- R10: Control bit 0 enables protection. When it is 0:
  - the memory lane is {8'h00, data};
  - a read returns the lane's low 64 bits unchanged;
  - no error bit, counter or capture is touched.
- R11: The write path passes straight through, with `wr_ready` equal to `mw_ready`. Read results appear on the clock edge that samples `mr_valid`.
- R12: After reset, the control register (register 0) reads 1 and every other register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Host write request |
| wr_ready | output | 1 | Host write accepted |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | LANES*64 | Host write data |
| mw_valid | output | 1 | Memory write request |
| mw_ready | input | 1 | Memory write accepted |
| mw_addr | output | ADDR_W | Memory write address |
| mw_data | output | LANES*72 | Encoded memory write data |
| mr_valid | input | 1 | Memory read data valid |
| mr_addr | input | ADDR_W | Address of returned read data |
| mr_data | input | LANES*72 | Returned codewords |
| rd_valid | output | 1 | Host read data valid |
| rd_addr | output | ADDR_W | Host read address |
| rd_data | output | LANES*64 | Corrected read data |
| rd_err | output | LANES | Per-lane uncorrectable error |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| irq_sbe | output | 1 | Single-error threshold interrupt |
| irq_dbe | output | 1 | Double-error threshold interrupt |

## Verification
The hardest state to reach from the ports is a counter pinned at its saturation value while an interrupt is armed and the capture record is being held or overwritten.

The bench builds its own memory: it takes each encoded write, inverts one or two randomly chosen, distinct bit positions per lane, and plays the word back as a read. Hundreds of such beats, with an error class picked at random per lane, drive the counters of a small-width instance into saturation. The capture mode is switched halfway through the run.

Directed beats cover the remaining cases:
- the injection codes;
- the pass-through mode;
- the exact cycle in which an interrupt rises after the threshold is crossed.

// File: rtl/ecc_guard.sv
module ecc_guard #(
  parameter int LANES  = 2,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_valid,
  output logic                  wr_ready,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [LANES*64-1:0]   wr_data,
  output logic                  mw_valid,
  input  logic                  mw_ready,
  output logic [ADDR_W-1:0]     mw_addr,
  output logic [LANES*72-1:0]   mw_data,
  input  logic                  mr_valid,
  input  logic [ADDR_W-1:0]     mr_addr,
  input  logic [LANES*72-1:0]   mr_data,
  output logic                  rd_valid,
  output logic [ADDR_W-1:0]     rd_addr,
  output logic [LANES*64-1:0]   rd_data,
  output logic [LANES-1:0]      rd_err,
  input  logic                  reg_we,
  input  logic [2:0]            reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  output logic                  irq_sbe,
  output logic                  irq_dbe
);
  localparam int DW = LANES * 64;

  function automatic logic [71:0] enc(input logic [63:0] d);
    logic [71:0] c;
    int k;
    c = '0;
    k = 0;
    for (int i = 1; i < 72; i++)
      if ((i & (i - 1)) != 0) begin
        c[i] = d[k];
        k++;
      end
    for (int i = 3; i < 72; i++)
      if ((i & (i - 1)) != 0)
        for (int b = 0; b < 7; b++)
          if (i[b]) c[1 << b] = c[1 << b] ^ c[i];
    c[0] = ^c;
    return c;
  endfunction

  function automatic void dec(input logic [71:0] cw, output logic [63:0] d,
                              output logic sb, output logic db, output logic [7:0] syn);
    logic [6:0]  s;
    logic        p;
    logic [71:0] c;
    int          k;
    s = '0;
    for (int i = 0; i < 72; i++)
      if (cw[i]) s = s ^ 7'(i);
    p  = ^cw;
    c  = cw;
    sb = p && (s < 7'd72);
    db = (!p && s != 7'd0) || (p && s >= 7'd72);
    if (sb) c[s] = ~c[s];
    d = '0;
    k = 0;
    for (int i = 1; i < 72; i++)
      if ((i & (i - 1)) != 0) begin
        d[k] = c[i];
        k++;
      end
    syn = {p, s};
  endfunction

  logic              ecc_en, cap_latest;
  logic [1:0]        inj_mode;
  logic [71:0]       inj_mask;
  logic [CNT_W-1:0]  sbe_cnt, dbe_cnt;
  logic [31:0]       sbe_thr, dbe_thr;
  logic              cap_vld, cap_dbl;
  logic [7:0]        cap_syn, cap_lane;
  logic [ADDR_W-1:0] cap_addr;

  logic [DW-1:0]     dec_d, raw_d;
  logic [LANES-1:0]  l_sbe, l_dbe;
  logic [7:0]        l_syn [LANES];

  assign inj_mask = (inj_mode == 2'b01) ? 72'h2 : (inj_mode == 2'b10) ? 72'h6 : 72'h0;
  assign mw_valid = wr_valid;
  assign mw_addr  = wr_addr;
  assign wr_ready = mw_ready;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [63:0] d;
    logic        sb, db;
    logic [7:0]  sy;
    assign mw_data[l*72 +: 72] = ecc_en ? (enc(wr_data[l*64 +: 64]) ^ inj_mask)
                                        : {8'h00, wr_data[l*64 +: 64]};
    always_comb dec(mr_data[l*72 +: 72], d, sb, db, sy);
    assign dec_d[l*64 +: 64] = d;
    assign raw_d[l*64 +: 64] = mr_data[l*72 +: 64];
    assign l_sbe[l] = sb;
    assign l_dbe[l] = db;
    assign l_syn[l] = sy;
  end

  logic       chk_en, err_any;
  logic       c_dbl;
  logic [7:0] c_syn, c_lane;

  always_comb begin
    c_dbl  = 1'b0;
    c_syn  = '0;
    c_lane = '0;
    for (int l = LANES - 1; l >= 0; l--)
      if (l_sbe[l] || l_dbe[l]) begin
        c_dbl  = l_dbe[l];
        c_syn  = l_syn[l];
        c_lane = l[7:0];
      end
  end

  assign chk_en  = mr_valid && ecc_en;
  assign err_any = chk_en && ((l_sbe | l_dbe) != '0);

  logic [CNT_W:0] sbe_sum, dbe_sum;
  assign sbe_sum = {1'b0, sbe_cnt} + (CNT_W+1)'($countones(l_sbe & {LANES{chk_en}}));
  assign dbe_sum = {1'b0, dbe_cnt} + (CNT_W+1)'($countones(l_dbe & {LANES{chk_en}}));

  logic wr_ctrl, clr_s, clr_d, wr_info;
  assign wr_ctrl = reg_we && reg_addr == 3'd0;
  assign clr_s   = reg_we && reg_addr == 3'd1 && reg_wdata[0];
  assign clr_d   = reg_we && reg_addr == 3'd1 && reg_wdata[1];
  assign wr_info = reg_we && reg_addr == 3'd7;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_addr  <= '0;
      rd_data  <= '0;
      rd_err   <= '0;
    end else begin
      rd_valid <= mr_valid;
      rd_addr  <= mr_addr;
      rd_data  <= ecc_en ? dec_d : raw_d;
      rd_err   <= chk_en ? l_dbe : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecc_en <= 1'b1; cap_latest <= 1'b0; inj_mode <= 2'b00;
      sbe_cnt <= '0; dbe_cnt <= '0; sbe_thr <= '0; dbe_thr <= '0;
      irq_sbe <= 1'b0; irq_dbe <= 1'b0;
      cap_vld <= 1'b0; cap_dbl <= 1'b0; cap_syn <= '0; cap_lane <= '0; cap_addr <= '0;
    end else begin
      if (wr_ctrl) begin
        ecc_en     <= reg_wdata[0];
        cap_latest <= reg_wdata[1];
        inj_mode   <= reg_wdata[3:2];
      end
      if (reg_we && reg_addr == 3'd4) sbe_thr <= reg_wdata;
      if (reg_we && reg_addr == 3'd5) dbe_thr <= reg_wdata;

      if (clr_s) sbe_cnt <= '0;
      else       sbe_cnt <= sbe_sum[CNT_W] ? '1 : sbe_sum[CNT_W-1:0];
      if (clr_d) dbe_cnt <= '0;
      else       dbe_cnt <= dbe_sum[CNT_W] ? '1 : dbe_sum[CNT_W-1:0];

      irq_sbe <= (irq_sbe || (32'(sbe_cnt) > sbe_thr)) && !clr_s;
      irq_dbe <= (irq_dbe || (32'(dbe_cnt) > dbe_thr)) && !clr_d;

      if (wr_info) cap_vld <= 1'b0;
      if (err_any && (!cap_vld || cap_latest)) begin
        cap_vld  <= 1'b1;
        cap_dbl  <= c_dbl;
        cap_syn  <= c_syn;
        cap_lane <= c_lane;
        cap_addr <= mr_addr;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {28'd0, inj_mode, cap_latest, ecc_en};
      3'd1:    reg_rdata = {30'd0, irq_dbe, irq_sbe};
      3'd2:    reg_rdata = 32'(sbe_cnt);
      3'd3:    reg_rdata = 32'(dbe_cnt);
      3'd4:    reg_rdata = sbe_thr;
      3'd5:    reg_rdata = dbe_thr;
      3'd6:    reg_rdata = 32'(cap_addr);
      default: reg_rdata = {8'd0, cap_lane, cap_syn, 6'd0, cap_dbl, cap_vld};
    endcase
  end
endmodule

module ecc_guard_chk #(
  parameter int LANES  = 2,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [2:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              rd_valid,
  input logic [LANES-1:0]  rd_err,
  input logic              irq_sbe,
  input logic              irq_dbe,
  input logic [CNT_W-1:0]  sbe_cnt,
  input logic [CNT_W-1:0]  dbe_cnt,
  input logic [31:0]       sbe_thr,
  input logic              ecc_en,
  input logic              cap_vld,
  input logic              cap_latest,
  input logic [ADDR_W-1:0] cap_addr
);
  logic ck_clr_s, ck_clr_d, ck_info;
  assign ck_clr_s = reg_we && reg_addr == 3'd1 && reg_wdata[0];
  assign ck_clr_d = reg_we && reg_addr == 3'd1 && reg_wdata[1];
  assign ck_info  = reg_we && reg_addr == 3'd7;

  assert_err_with_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_err != '0) |-> rd_valid);
  assert_sbe_no_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ck_clr_s) |-> sbe_cnt >= $past(sbe_cnt));
  assert_dbe_no_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ck_clr_d) |-> dbe_cnt >= $past(dbe_cnt));
  assert_irq_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq_sbe) && !$past(ck_clr_s)) |-> irq_sbe);
  assert_irq_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_sbe) |-> $past(32'(sbe_cnt) > sbe_thr));
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ck_clr_s) |-> (sbe_cnt == '0 && !irq_sbe));
  assert_first_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cap_vld && !cap_latest) && !$past(ck_info)) |-> $stable(cap_addr));
  assert_off_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!ecc_en) |-> rd_err == '0);
  assert_dbe_irq_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq_dbe) && !$past(ck_clr_d)) |-> irq_dbe);
endmodule

bind ecc_guard ecc_guard_chk #(.LANES(LANES), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .rd_valid(rd_valid), .rd_err(rd_err), .irq_sbe(irq_sbe), .irq_dbe(irq_dbe),
  .sbe_cnt(sbe_cnt), .dbe_cnt(dbe_cnt), .sbe_thr(sbe_thr), .ecc_en(ecc_en),
  .cap_vld(cap_vld), .cap_latest(cap_latest), .cap_addr(cap_addr));

// File: tb/ecc_guard_tb_top.sv
`timescale 1ns/1ps
module ecc_guard_tb_top;
  localparam int LANES = 2, AW = 16, CW_N = 6;
  localparam int DW = LANES * 64, CW = LANES * 72;
  localparam int SAT = (1 << CW_N) - 1;

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, wr_ready, mw_valid, mw_ready = 1;
  logic [AW-1:0] wr_addr = 0, mw_addr, mr_addr = 0, rd_addr;
  logic [DW-1:0] wr_data = 0, rd_data;
  logic [CW-1:0] mw_data, mr_data = 0;
  logic mr_valid = 0, rd_valid;
  logic [LANES-1:0] rd_err;
  logic reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq_sbe, irq_dbe;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ecc_guard #(.LANES(LANES), .ADDR_W(AW), .CNT_W(CW_N)) dut_i (.*);

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, output logic [CW-1:0] cw);
    @(negedge clk); wr_valid = 1; wr_addr = a; wr_data = d; mw_ready = 1;
    #1 cw = mw_data;
    @(negedge clk); wr_valid = 0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [CW-1:0] cw,
                         output logic [DW-1:0] d, output logic [LANES-1:0] e);
    @(negedge clk); mr_valid = 1; mr_addr = a; mr_data = cw;
    @(posedge clk); #2;
    d = rd_data; e = rd_err;
    chk("R11 rd_valid", rd_valid, 1); chk("R11 rd_addr", rd_addr, a);
    @(negedge clk); mr_valid = 0;
  endtask

  function automatic logic [7:0] syn_of(input int nf, input int p0, input int p1);
    if (nf == 1) return {1'b1, 7'(p0)};
    return {1'b0, 7'(p0 ^ p1)};
  endfunction

  function automatic int sat_add(input int c, input int n);
    return (c + n > SAT) ? SAT : c + n;
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [CW-1:0] cw, cw2;
    logic [DW-1:0] d, got;
    logic [LANES-1:0] e;
    int sbe_m, dbe_m;
    bit capv, capd, irqs, irqd;
    logic [7:0] caps, capl;
    logic [AW-1:0] capa;

    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12 reset values
    for (int r = 0; r < 8; r++) begin
      reg_rd(3'(r), v);
      chk($sformatf("R12 reg%0d", r), v, (r == 0) ? 1 : 0);
    end
    chk("R12 irq", {irq_sbe, irq_dbe, rd_valid}, 0);

    // R11 write passthrough handshake
    @(negedge clk); mw_ready = 0; wr_valid = 1; wr_addr = 16'h1234; #1
    chk("R11 wr_ready", wr_ready, 0); chk("R11 mw_valid", mw_valid, 1); chk("R11 mw_addr", mw_addr, 16'h1234);
    @(negedge clk); mw_ready = 1; wr_valid = 0;

    // R1 clean loopback and bit-0 parity
    d = {64'hDEAD_BEEF_0123_4567, 64'h0};
    do_write(16'h10, d, cw);
    chk("R1 parity lane0", ^cw[71:0], 0);
    chk("R1 parity lane1", ^cw[143:72], 0);
    chk("R1 zero lane codeword", cw[71:0], 0);
    do_read(16'h10, cw, got, e);
    chk("R1 data", got, d); chk("R1 err", e, 0);

    // R10 protection off
    reg_wr(0, 32'h0);
    d = {64'hA5A5_5A5A_0F0F_F0F0, 64'h1111_2222_3333_4444};
    do_write(16'h20, d, cw);
    chk("R10 write lanes", cw, {8'h00, d[127:64], 8'h00, d[63:0]});
    cw2 = cw ^ {8'hFF, 64'h3, 8'hFF, 64'h1};
    do_read(16'h20, cw2, got, e);
    chk("R10 read raw", got, d ^ {64'h3, 64'h1}); chk("R10 no err", e, 0);
    reg_rd(2, v); chk("R10 sbe cnt", v, 0);
    reg_rd(3, v); chk("R10 dbe cnt", v, 0);
    reg_rd(7, v); chk("R10 no capture", v[0], 0);

    // R9 injection
    d = {64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210};
    reg_wr(0, 32'h1);
    do_write(16'h30, d, cw);
    reg_wr(0, 32'h5);
    do_write(16'h30, d, cw2);
    chk("R9 single mask", cw ^ cw2, {72'h2, 72'h2});
    do_read(16'h30, cw2, got, e);
    chk("R9 single data", got, d); chk("R9 single err", e, 0);
    reg_rd(2, v); chk("R9 single count", v, LANES);
    reg_rd(7, v); chk("R9 single info", v, {8'd0, 8'd0, 8'h81, 8'h01});
    reg_wr(7, 0);
    reg_wr(0, 32'h9);
    do_write(16'h31, d, cw2);
    chk("R9 double mask", cw ^ cw2, {72'h6, 72'h6});
    do_read(16'h31, cw2, got, e);
    chk("R9 double err", e, {LANES{1'b1}});
    reg_rd(3, v); chk("R9 double count", v, LANES);
    reg_rd(7, v); chk("R9 double info", v, {8'd0, 8'd0, 8'h03, 8'h03});
    reg_rd(6, v); chk("R7 capture addr", v, 16'h31);
    reg_wr(0, 32'h1);

    // R5 / R6 threshold timing and clear
    reg_wr(1, 32'h3);
    reg_rd(2, v); chk("R6 sbe cleared", v, 0);
    reg_rd(3, v); chk("R6 dbe cleared", v, 0);
    reg_wr(4, 32'h0);
    do_write(16'h40, d, cw);
    @(negedge clk); mr_valid = 1; mr_addr = 16'h40; mr_data = cw ^ {72'h0, 72'h1 << 37};
    @(posedge clk); #2;
    chk("R2 corrected", rd_data, d);
    chk("R5 irq not yet", irq_sbe, 0);
    @(negedge clk); mr_valid = 0;
    @(posedge clk); #2;
    chk("R5 irq next cycle", irq_sbe, 1);
    repeat (3) @(posedge clk); #2;
    chk("R5 sticky", irq_sbe, 1);
    reg_wr(1, 32'h1);
    chk("R6 irq cleared", irq_sbe, 0);
    reg_rd(2, v); chk("R6 counter cleared", v, 0);
    reg_rd(1, v); chk("R6 status", v, 0);

    // random phase: R2 R3 R4 R5 R7 R8
    void'($urandom(32'h5EED_1234));
    reg_wr(4, 40); reg_wr(5, 50);
    reg_wr(1, 3); reg_wr(7, 0); reg_wr(0, 1);
    sbe_m = 0; dbe_m = 0; capv = 0; capd = 0; caps = 0; capl = 0; capa = 0;
    for (int it = 0; it < 300; it++) begin
      logic [CW-1:0] mask;
      logic [LANES-1:0] ee;
      int ns, nd;
      bit latest;
      latest = (it >= 150);
      if (it == 150) reg_wr(0, 3);
      d = {$urandom, $urandom, $urandom, $urandom};
      mask = '0; ee = '0; ns = 0; nd = 0;
      do_write(16'(it), d, cw);
      for (int l = LANES - 1; l >= 0; l--) begin
        int nf, p0, p1;
        nf = $urandom % 3; p0 = $urandom % 72; p1 = (p0 + 1 + $urandom % 71) % 72;
        if (nf >= 1) mask[l*72 + p0] = 1'b1;
        if (nf == 2) mask[l*72 + p1] = 1'b1;
        if (nf == 1) ns++;
        if (nf == 2) begin nd++; ee[l] = 1'b1; end
        if (nf != 0 && (!capv || latest)) begin
          capd = (nf == 2); caps = syn_of(nf, p0, p1); capl = 8'(l); capa = 16'(it);
        end
      end
      if (mask != '0) capv = 1;
      do_read(16'(it), cw ^ mask, got, e);
      chk("R3 err bits", e, ee);
      for (int l = 0; l < LANES; l++)
        if (!ee[l]) chk("R2 lane data", got[l*64 +: 64], d[l*64 +: 64]);
      sbe_m = sat_add(sbe_m, ns); dbe_m = sat_add(dbe_m, nd);
      if (sbe_m > 40) irqs = 1;
      if (dbe_m > 50) irqd = 1;
      if (it % 25 == 24) begin
        reg_rd(2, v); chk("R4 sbe count", v, sbe_m);
        reg_rd(3, v); chk("R4 dbe count", v, dbe_m);
        reg_rd(6, v); chk("R8 capture addr", v, capa);
        reg_rd(7, v); chk("R7 capture info", v, {8'd0, capl, caps, 6'd0, capd, capv});
      end
    end
    chk("R4 sbe saturated", sbe_m, SAT);
    reg_rd(1, v);
    chk("R5 status", v, {30'd0, irqd, irqs});
    chk("R5 irq pins", {irq_dbe, irq_sbe}, {irqd, irqs});
    reg_wr(7, 0);
    reg_rd(7, v); chk("R8 info cleared", v[0], 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule